// File: doc/BRIEF.md
# USB Endpoint Command Status Engine

This block holds the per-endpoint status of a USB device controller and is driven through a byte-wide command port. For each physical endpoint it keeps a stall flag, a data toggle (the PID expected or sent next) and two buffer-full flags. Endpoint 0 is the control OUT endpoint and also keeps a setup-received flag and a setup-overwritten flag. A vector of endpoint interrupt bits sits beside them. The endpoints are numbered so that even numbers are OUT and odd numbers are IN, and endpoints 0 and 1 form the control pair.

Software issues a select-and-clear read command for one endpoint and then pulls exactly one status byte. Pulling that byte completes the command, and completion clears the endpoint's interrupt bit. A set-status write stalls or unstalls an endpoint. Every such write also re-initializes the endpoint: its buffers are emptied and its toggle returns to DATA0. A SETUP token on a stalled control endpoint lifts the stall in the same way.

Packet-completion pulses from the serial engine fill the buffers and flip the toggle. Interrupt-set pulses raise interrupt bits. None of the stall or re-initialization actions touch the interrupt vector.

Top module: `usb_ep_status_engine`

## Requirements
- R1: After reset every stall flag, toggle (0 = DATA0), buffer flag, setup/overwrite flag and interrupt bit is 0, and rdValid is 0.
- R2: A read command (cmdValid=1, cmdWrite=0, opcode 0x40+n, n < NUM_EP) followed by a cycle with rdReq=1 gives rdValid=1 one cycle later, with rdData = {0, buf2Full, buf1Full, toggle, overwrite, setup, stall, buf1Full|buf2Full}, bit 7 always 0, sampled before that cycle's updates.
- R3: An intSet[n] pulse sets interrupt bit n; completing the read of endpoint n clears it, and no other endpoint's bit changes.
- R4: Completing a read of endpoint 0 clears its setup and overwrite flags; reads of other endpoints leave them unchanged.
- R5: Each read command yields exactly one byte: rdReq with no read pending gives no rdValid, and opcodes outside 0x40..0x40+NUM_EP-1 start no read.
- R6: A write (cmdWrite=1, cmdHasData=1, opcode 0x40+n, n < min(NUM_EP,22)) sets stall = data bit 0, empties both buffers and sets the toggle to data bit 5 (0 = DATA0). A write without its data byte, or with an opcode out of range, changes nothing.
- R7: Data bits 7:6 and 4:1 of a write have no effect.
- R8: A SETUP event on a stalled endpoint 0 or 1 clears its stall, empties its buffers and sets DATA0. A SETUP event on endpoint 0 sets the setup flag, and sets the overwrite flag if the setup flag was already 1. SETUP events on endpoints 2 and up are ignored.
- R9: Stalling, unstalling and re-initializing never change any interrupt bit.
- R10: A pktDone[n] pulse on an unstalled endpoint flips its toggle and fills buffer 1 if it is empty, else buffer 2. On a stalled endpoint it has no effect.
- R11: When a write and a packet or SETUP event hit the same endpoint in one cycle, the write's result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdWrite | input | 1 | 1 = set-status write, 0 = select-and-clear read |
| cmdOpcode | input | 8 | Command code, 0x40 + endpoint |
| cmdHasData | input | 1 | The write carries its data byte |
| cmdData | input | 8 | Write data byte |
| rdReq | input | 1 | Pull the pending status byte |
| setupEvt | input | NUM_EP | SETUP token received, per endpoint |
| pktDone | input | NUM_EP | Packet completed, per endpoint |
| intSet | input | NUM_EP | Interrupt-set pulses |
| rdData | output | 8 | Returned status byte |
| rdValid | output | 1 | rdData is valid this cycle |
| stallFlags | output | NUM_EP | Stall flag per endpoint |
| dataPid | output | NUM_EP | Next data PID per endpoint, 0 = DATA0 |
| intStatus | output | NUM_EP | Endpoint interrupt vector |

## Verification
The checker watches several rules on every cycle. A returned byte must follow a pull and must have bit 7 clear. After each write, the stall flag and toggle must equal the written bits. An interrupt bit may fall only after a pull, and an interrupt-set pulse must always take effect. A SETUP event on a stalled control endpoint must lift the stall.

The bench scenarios cover what needs history. They check the buffer fill order, the flag contents of the status byte, and the clearing of the setup and overwrite flags. They also check that ignored stimulus (stalled packets, missing data bytes, out-of-range opcodes, unused write bits) changes nothing, and that a write wins a same-cycle collision.

// File: rtl/usb_ep_status_pkg.sv
package usb_ep_status_pkg;
  localparam int EP_IDX_W = 5;
  localparam int MAX_EP = 32;
  localparam int MAX_WR_EP = 22;
  localparam logic [7:0] CMD_BASE = 8'h40;

  typedef struct packed {
    logic                wrEn;
    logic [EP_IDX_W-1:0] wrEp;
    logic [7:0]          wrByte;
    logic                rdDone;
    logic [EP_IDX_W-1:0] rdEp;
  } cmdStrobe_t;
endpackage

// File: rtl/ep_cmd_ctrl.sv
module ep_cmd_ctrl
  import usb_ep_status_pkg::*;
#(
  parameter int NUM_EP = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdWrite,
  input  logic [7:0] cmdOpcode,
  input  logic       cmdHasData,
  input  logic [7:0] cmdData,
  input  logic       rdReq,
  output cmdStrobe_t strb
);
  localparam int NUM_WR = (NUM_EP < MAX_WR_EP) ? NUM_EP : MAX_WR_EP;
  localparam logic [7:0] RD_LIM = 8'(NUM_EP);
  localparam logic [7:0] WR_LIM = 8'(NUM_WR);

  logic [7:0] offs;
  logic isCmd, rdCmd, wrOk;
  logic pending;
  logic [EP_IDX_W-1:0] pendEp;

  assign offs  = cmdOpcode - CMD_BASE;
  assign isCmd = cmdValid && (cmdOpcode >= CMD_BASE);
  assign rdCmd = isCmd && !cmdWrite && (offs < RD_LIM);
  assign wrOk  = isCmd && cmdWrite && cmdHasData && (offs < WR_LIM);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      pendEp  <= '0;
    end else if (rdCmd) begin
      pending <= 1'b1;
      pendEp  <= offs[EP_IDX_W-1:0];
    end else if (rdReq && pending) begin
      pending <= 1'b0;
    end
  end

  always_comb begin
    strb.wrEn   = wrOk;
    strb.wrEp   = offs[EP_IDX_W-1:0];
    strb.wrByte = cmdData;
    strb.rdDone = rdReq && pending;
    strb.rdEp   = pendEp;
  end
endmodule

// File: rtl/ep_status_dp.sv
module ep_status_dp
  import usb_ep_status_pkg::*;
#(
  parameter int NUM_EP = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobe_t        strb,
  input  logic [NUM_EP-1:0] setupEvt,
  input  logic [NUM_EP-1:0] pktDone,
  input  logic [NUM_EP-1:0] intSet,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic [NUM_EP-1:0] stallFlags,
  output logic [NUM_EP-1:0] dataPid,
  output logic [NUM_EP-1:0] intStatus
);
  logic [7:0] epStatus [NUM_EP];
  logic [NUM_EP-1:0] rdMask;
  logic [NUM_EP-1:0] intQ;
  logic setupQ, ovrQ, setupN, ovrN;
  logic [7:0] selByte;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    localparam bit IS_CTRL = (i < 2);
    localparam bit IS_EP0 = (i == 0);
    logic stallQ, pidQ, b1Q, b2Q;
    logic stallN, pidN, b1N, b2N;
    logic wrHere;

    assign wrHere = strb.wrEn && (strb.wrEp == EP_IDX_W'(i));

    always_comb begin
      stallN = stallQ;
      pidN   = pidQ;
      b1N    = b1Q;
      b2N    = b2Q;
      if (pktDone[i] && !stallQ) begin
        pidN = ~pidQ;
        if (!b1Q) b1N = 1'b1;
        else      b2N = 1'b1;
      end
      if (IS_CTRL && setupEvt[i] && stallQ) begin
        stallN = 1'b0;
        pidN   = 1'b0;
        b1N    = 1'b0;
        b2N    = 1'b0;
      end
      if (wrHere) begin
        stallN = strb.wrByte[0];
        pidN   = strb.wrByte[5];
        b1N    = 1'b0;
        b2N    = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stallQ <= 1'b0;
        pidQ   <= 1'b0;
        b1Q    <= 1'b0;
        b2Q    <= 1'b0;
      end else begin
        stallQ <= stallN;
        pidQ   <= pidN;
        b1Q    <= b1N;
        b2Q    <= b2N;
      end
    end

    assign epStatus[i] = {1'b0, b2Q, b1Q, pidQ,
                          IS_EP0 ? ovrQ : 1'b0,
                          IS_EP0 ? setupQ : 1'b0,
                          stallQ, b1Q | b2Q};
    assign stallFlags[i] = stallQ;
    assign dataPid[i]    = pidQ;
    assign rdMask[i]     = strb.rdDone && (strb.rdEp == EP_IDX_W'(i));
  end

  always_comb begin
    setupN = setupQ;
    ovrN   = ovrQ;
    if (rdMask[0]) begin
      setupN = 1'b0;
      ovrN   = 1'b0;
    end
    if (setupEvt[0]) begin
      ovrN   = ovrN | setupN;
      setupN = 1'b1;
    end
  end

  always_comb begin
    selByte = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (strb.rdEp == EP_IDX_W'(i)) selByte = epStatus[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intQ    <= '0;
      setupQ  <= 1'b0;
      ovrQ    <= 1'b0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      intQ    <= (intQ & ~rdMask) | intSet;
      setupQ  <= setupN;
      ovrQ    <= ovrN;
      rdValid <= strb.rdDone;
      if (strb.rdDone) rdData <= selByte;
    end
  end

  assign intStatus = intQ;
endmodule

// File: rtl/usb_ep_status_engine.sv
module usb_ep_status_engine
  import usb_ep_status_pkg::*;
#(
  parameter int NUM_EP = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdWrite,
  input  logic [7:0]        cmdOpcode,
  input  logic              cmdHasData,
  input  logic [7:0]        cmdData,
  input  logic              rdReq,
  input  logic [NUM_EP-1:0] setupEvt,
  input  logic [NUM_EP-1:0] pktDone,
  input  logic [NUM_EP-1:0] intSet,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic [NUM_EP-1:0] stallFlags,
  output logic [NUM_EP-1:0] dataPid,
  output logic [NUM_EP-1:0] intStatus
);
  cmdStrobe_t strb;

  ep_cmd_ctrl #(.NUM_EP(NUM_EP)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdOpcode(cmdOpcode), .cmdHasData(cmdHasData), .cmdData(cmdData),
    .rdReq(rdReq), .strb(strb)
  );

  ep_status_dp #(.NUM_EP(NUM_EP)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .setupEvt(setupEvt),
    .pktDone(pktDone), .intSet(intSet), .rdData(rdData), .rdValid(rdValid),
    .stallFlags(stallFlags), .dataPid(dataPid), .intStatus(intStatus)
  );
endmodule

// File: rtl/ep_status_checker.sv
module ep_status_checker #(
  parameter int NUM_EP = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdWrite,
  input logic [7:0]        cmdOpcode,
  input logic              cmdHasData,
  input logic [7:0]        cmdData,
  input logic              rdReq,
  input logic [NUM_EP-1:0] setupEvt,
  input logic [NUM_EP-1:0] intSet,
  input logic [7:0]        rdData,
  input logic              rdValid,
  input logic [NUM_EP-1:0] stallFlags,
  input logic [NUM_EP-1:0] dataPid,
  input logic [NUM_EP-1:0] intStatus
);
  localparam int EP_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1;
  localparam int NUM_WR = (NUM_EP < 22) ? NUM_EP : 22;
  logic [7:0] wrIdx;
  logic wrHit;
  logic [EP_W-1:0] wrSel;

  assign wrIdx = cmdOpcode - 8'h40;
  assign wrSel = wrIdx[EP_W-1:0];
  assign wrHit = cmdValid && cmdWrite && cmdHasData && (cmdOpcode >= 8'h40)
                 && (wrIdx < 8'(NUM_WR));

  p_byte_needs_pull_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdReq));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !rdData[7]);

  p_stall_follows_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrHit |=> stallFlags[$past(wrSel)] == $past(cmdData[0]));

  p_pid_follows_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrHit |=> dataPid[$past(wrSel)] == $past(cmdData[5]));

  for (genvar i = 0; i < NUM_EP; i++) begin : g_int
    p_int_set_r3: assert property (@(posedge clk) disable iff (!rstN)
      intSet[i] |=> intStatus[i]);
    p_int_fall_only_on_pull_r9: assert property (@(posedge clk) disable iff (!rstN)
      $fell(intStatus[i]) |-> $past(rdReq));
  end

  for (genvar i = 0; i < 2; i++) begin : g_ctrl
    p_setup_unstalls_r8: assert property (@(posedge clk) disable iff (!rstN)
      (setupEvt[i] && stallFlags[i] && !(wrHit && wrIdx == 8'(i))) |=> !stallFlags[i]);
  end
endmodule

bind usb_ep_status_engine ep_status_checker #(.NUM_EP(NUM_EP)) u_chk (.*);

// File: tb/test_usb_ep_status_engine.sv
module test_usb_ep_status_engine;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 0, cmdWrite = 0, cmdHasData = 0, rdReq = 0;
  logic [7:0] cmdOpcode = 0, cmdData = 0;
  logic [N-1:0] setupEvt = '0, pktDone = '0, intSet = '0;
  logic [7:0] rdData;
  logic rdValid;
  logic [N-1:0] stallFlags, dataPid, intStatus;

  bit mStall[N], mPid[N], mB1[N], mB2[N], mInt[N];
  bit mSetup, mOvr;
  int checks = 0, failures = 0;
  bit done = 0;

  usb_ep_status_engine #(.NUM_EP(N)) i_usb_ep_status_engine (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] vecOf(input int which);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++)
      v[i] = (which == 0) ? mStall[i] : (which == 1) ? mPid[i] : mInt[i];
    return v;
  endfunction

  function automatic logic [7:0] expByte(input int n);
    return {1'b0, mB2[n], mB1[n], mPid[n], (n == 0) ? mOvr : 1'b0,
            (n == 0) ? mSetup : 1'b0, mStall[n], mB1[n] | mB2[n]};
  endfunction

  task automatic checkVecs(input string req);
    check(stallFlags == vecOf(0), {req, " stall"}, stallFlags, vecOf(0));
    check(dataPid == vecOf(1), {req, " pid"}, dataPid, vecOf(1));
    check(intStatus == vecOf(2), {req, " int"}, intStatus, vecOf(2));
  endtask

  task automatic modelWrite(input int n, input logic [7:0] d);
    mStall[n] = d[0]; mPid[n] = d[5]; mB1[n] = 0; mB2[n] = 0;
  endtask

  task automatic modelPkt(input int n);
    if (!mStall[n]) begin
      mPid[n] = !mPid[n];
      if (!mB1[n]) mB1[n] = 1; else mB2[n] = 1;
    end
  endtask

  task automatic doWrite(input logic [7:0] op, input logic [7:0] d, input bit hasData);
    cmdValid = 1; cmdWrite = 1; cmdOpcode = op; cmdData = d; cmdHasData = hasData;
    @(negedge clk);
    cmdValid = 0; cmdWrite = 0; cmdHasData = 0;
    if (hasData && op >= 8'h40 && op < 8'h40 + N) modelWrite(op - 8'h40, d);
  endtask

  task automatic doPkt(input int n);
    pktDone[n] = 1;
    @(negedge clk);
    pktDone[n] = 0;
    modelPkt(n);
  endtask

  task automatic doSetup(input int n);
    setupEvt[n] = 1;
    @(negedge clk);
    setupEvt[n] = 0;
    if (n < 2 && mStall[n]) begin
      mStall[n] = 0; mPid[n] = 0; mB1[n] = 0; mB2[n] = 0;
    end
    if (n == 0) begin
      mOvr = mOvr | mSetup; mSetup = 1;
    end
  endtask

  task automatic doInt(input int n);
    intSet[n] = 1;
    @(negedge clk);
    intSet[n] = 0;
    mInt[n] = 1;
  endtask

  task automatic doRead(input int n, input string req);
    logic [7:0] e;
    cmdValid = 1; cmdWrite = 0; cmdOpcode = 8'h40 + 8'(n);
    @(negedge clk);
    cmdValid = 0; rdReq = 1;
    e = expByte(n);
    @(negedge clk);
    rdReq = 0;
    mInt[n] = 0;
    if (n == 0) begin mSetup = 0; mOvr = 0; end
    check(rdValid === 1'b1, {req, " rdValid"}, rdValid, 1);
    check(rdData === e, {req, " byte"}, rdData, e);
    check(intStatus == vecOf(2), "R3 read clears int", intStatus, vecOf(2));
  endtask

  task automatic strayPull(input string req);
    rdReq = 1;
    @(negedge clk);
    rdReq = 0;
    check(rdValid === 1'b0, req, rdValid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    checkVecs("R1 reset");
    check(rdValid === 1'b0, "R1 rdValid", rdValid, 0);

    // R3 / R2 / R5: set interrupts on every endpoint, read each one
    for (int n = 0; n < N; n++) doInt(n);
    checkVecs("R3 intSet");
    for (int n = 0; n < N; n++) begin
      doRead(n, "R2 sweep");
      strayPull("R5 second pull");
    end

    // R10: fill order and toggle with 0..3 packets per endpoint
    for (int n = 0; n < N; n++)
      for (int k = 0; k < (n % 4); k++) doPkt(n);
    checkVecs("R10 packets");
    for (int n = 0; n < N; n++) doRead(n, "R10 byte");

    // R6/R7/R9: writes with varied ignored bits, interrupts held high
    for (int n = 0; n < N; n++) doInt(n);
    for (int n = 0; n < N; n++) begin
      logic [7:0] d;
      d = 8'((n * 8'h5B) ^ 8'hC6);
      doPkt(n);
      doWrite(8'h40 + 8'(n), d, 1);
      checkVecs("R6 R7 R9 write");
    end
    for (int n = 0; n < N; n++) doRead(n, "R6 byte after write");

    // R7: same effective bits, all ignored bits flipped, same result
    doWrite(8'h42, 8'h21, 1);
    doWrite(8'h42, 8'hFF & ~8'h20 & ~8'h01 | 8'h21, 1);
    checkVecs("R7 ignored bits");

    // R10: packets on a stalled endpoint ignored
    doWrite(8'h43, 8'h01, 1);
    doPkt(3);
    checkVecs("R10 stalled");
    doRead(3, "R10 stalled byte");

    // R6: no data byte, out-of-range opcode
    doWrite(8'h44, 8'h01, 0);
    doWrite(8'h40 + 8'(N), 8'h21, 1);
    doWrite(8'h3F, 8'h01, 1);
    checkVecs("R6 no effect");

    // R5: out-of-range read opcodes start nothing
    cmdValid = 1; cmdWrite = 0; cmdOpcode = 8'h3F;
    @(negedge clk);
    cmdValid = 0;
    strayPull("R5 low opcode");
    cmdValid = 1; cmdOpcode = 8'h40 + 8'(N);
    @(negedge clk);
    cmdValid = 0;
    strayPull("R5 high opcode");

    // R8 / R4: setup on stalled control endpoints
    doWrite(8'h40, 8'h01, 1);
    doPkt(0);
    doInt(0);
    doSetup(0);
    checkVecs("R8 ep0 unstall R9");
    doSetup(0);
    doRead(2, "R4 other read");
    doRead(0, "R4 setup+overwrite byte");
    doRead(0, "R4 flags cleared");
    doWrite(8'h41, 8'h21, 1);
    doSetup(1);
    checkVecs("R8 ep1 unstall");
    doWrite(8'h43, 8'h01, 1);
    doSetup(3);
    checkVecs("R8 non-control ignored");
    doRead(1, "R8 ep1 byte");

    // R11: write and packet collide on one endpoint
    pktDone[4] = 1;
    cmdValid = 1; cmdWrite = 1; cmdHasData = 1; cmdOpcode = 8'h44; cmdData = 8'h01;
    @(negedge clk);
    pktDone[4] = 0; cmdValid = 0; cmdWrite = 0; cmdHasData = 0;
    modelWrite(4, 8'h01);
    checkVecs("R11 collision");
    doRead(4, "R11 byte");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule